// File: doc/BRIEF.md
# Extended-Range Radio Event Timer

This block is a 40-bit time base for placing packet events on a precise timeline. A 16-bit base counter runs from zero up to a programmable period and then starts over, and a 24-bit overflow counter counts how many such periods have elapsed. Together they form a 40-bit timestamp of the form `{overflow, base}`. The radio controller pulses a frame-start or packet-end strobe, and the full 40-bit time is captured in that same clock cycle.

Two compare channels watch the base counter and two watch the overflow counter. A channel pulses for exactly one cycle on the tick where its counter becomes equal to the compare value. A routing byte sends each of the four match sources to the receive-start output, the transmit-start output, the interrupt output, or to none of them. All setup and readback goes through a byte-wide register bus.

Counting is governed by a two-state machine. In `TB_HALT` the counters hold their values. In `TB_RUN` they advance once per clock. The transition `TB_HALT -> TB_RUN` is taken when the enable bit is set. The transition `TB_RUN -> TB_HALT` is taken when the enable bit is cleared. Each state otherwise stays where it is.

Top module: `ftmr_top`

## Requirements
- R1: While running, the base counter advances by one per clock from 0 up to the period value inclusive and returns to 0 on the following tick. If the period is lowered below the current count, the base counter returns to 0 on the next tick.
- R2: The overflow counter advances by one on each tick where the base counter returns to 0, and at no other time.
- R3: A pulse on either `evt_sof` or `evt_eop` captures `{overflow, base}` as a 40-bit value at that clock edge, with the base in bits 15:0.
- R4: Reading capture byte 0 (address 13) returns bits 7:0 and, in the same access, copies the whole capture into a shadow. Addresses 14 to 17 return shadow bytes 1 to 4, so a later capture cannot tear a multi-byte read.
- R5: Each of the two base compares (addresses 3/4 and 5/6, low byte first) pulses for one cycle on the tick where the base counter becomes equal to its value.
- R6: Each of the two overflow compares (addresses 7 to 9 and 10 to 12, low byte first) pulses for one cycle on the wrap tick where the overflow counter becomes equal to its value.
- R7: Route byte (address 18) holds two bits per source. Source 0 is base compare 0, source 1 is base compare 1, source 2 is overflow compare 0 and source 3 is overflow compare 1, and source s occupies bits 2s+1:2s. The codes are 00 none, 01 `start_rx`, 10 `start_tx` and 11 `evt_irq`.
- R8: Enable is bit 0 at address 0. The first increment happens on the second clock edge after the write that sets it. After a clear, one more increment takes place, and then the counters hold their values until enable is set again, when counting resumes from the held values.
- R9: After reset, enable and route are 0, the period (addresses 1/2) is 0xFFFF, the compares and capture are 0, and all outputs are low. Written setup registers read back their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (loads the capture shadow at address 13) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_sof | input | 1 | Frame-start strobe, captures the time |
| evt_eop | input | 1 | Packet-end strobe, captures the time |
| start_rx | output | 1 | Receive-start pulse from routed matches |
| start_tx | output | 1 | Transmit-start pulse from routed matches |
| evt_irq | output | 1 | Interrupt pulse from routed matches |

## Verification
The assertions check the following on every cycle:
- the base counter either steps by one or returns to zero when the machine runs;
- both counters hold in `TB_HALT`;
- the overflow counter moves only when the base counter is at zero;
- a capture equals the counters at the strobe edge;
- the shadow changes only on a byte-0 capture read;
- every match pulse coincides with its counter equal to the compare value, and lasts one cycle.

The directed scenarios are needed for the following:
- the absolute timing of the first increment and of the freeze;
- the inclusive-period wrap count, including the case where the period is lowered;
- the exact edges where the routed pulses land;
- the tear-free multi-byte capture read with a second strobe in between.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
    typedef enum logic {
        TB_HALT = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    localparam int NCH = 2;          // compare channels per counter
    localparam int NSRC = 2 * NCH;   // match sources feeding the router

    localparam logic [1:0] RT_NONE = 2'b00;
    localparam logic [1:0] RT_RX   = 2'b01;
    localparam logic [1:0] RT_TX   = 2'b10;
    localparam logic [1:0] RT_IRQ  = 2'b11;
endpackage

// File: rtl/ftmr_count.sv
module ftmr_count #(
    parameter int BASE_W = 16,
    parameter int OVF_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [BASE_W-1:0] period,
    output logic [BASE_W-1:0] base_q,
    output logic [OVF_W-1:0]  ovf_q,
    output logic [BASE_W-1:0] base_nx,
    output logic [OVF_W-1:0]  ovf_nx,
    output logic              tick,
    output logic              wrap
);
    import ftmr_pkg::*;

    tb_state_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            TB_HALT: if (run_en)  st_nx = TB_RUN;
            TB_RUN:  if (!run_en) st_nx = TB_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TB_HALT;
        else        st_q <= st_nx;
    end

    always_comb begin
        tick    = (st_q == TB_RUN);
        wrap    = tick && (base_q >= period);
        base_nx = wrap ? '0 : (tick ? base_q + BASE_W'(1) : base_q);
        ovf_nx  = wrap ? ovf_q + OVF_W'(1) : ovf_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ovf_q  <= '0;
        end else begin
            base_q <= base_nx;
            ovf_q  <= ovf_nx;
        end
    end

    // R1: a running tick either steps the base by one or returns it to zero
    assert_base_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (base_q == $past(base_q) + BASE_W'(1)) || (base_q == '0));

    // R2: the overflow counter only moves together with a base return to zero
    assert_ovf_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q != $past(ovf_q)) |-> (base_q == '0));

    // R8: a halted machine leaves both counters untouched
    assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(base_q) && $stable(ovf_q));
endmodule

// File: rtl/ftmr_match.sv
module ftmr_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] cnt_nx,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= step && (cnt_nx == cmp);
    end

    // R5 and R6: a pulse is only seen while the counter holds the compare value
    assert_hit_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cnt_q == $past(cmp)));
endmodule

// File: rtl/ftmr_regs.sv
module ftmr_regs #(
    parameter int BASE_W = 16,
    parameter int OVF_W  = 24,
    parameter int ADDR_W = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_wr,
    input  logic                                 bus_rd,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [7:0]                           bus_wdata,
    output logic [7:0]                           bus_rdata,
    input  logic                                 evt_sof,
    input  logic                                 evt_eop,
    input  logic [BASE_W-1:0]                    base_cnt,
    input  logic [OVF_W-1:0]                     ovf_cnt,
    output logic                                 run_en,
    output logic [BASE_W-1:0]                    period,
    output logic [ftmr_pkg::NCH-1:0][BASE_W-1:0] cmp_base,
    output logic [ftmr_pkg::NCH-1:0][OVF_W-1:0]  cmp_ovf,
    output logic [7:0]                           route
);
    import ftmr_pkg::*;

    localparam int BB    = (BASE_W + 7) / 8;
    localparam int OB    = (OVF_W + 7) / 8;
    localparam int CW    = BASE_W + OVF_W;
    localparam int CB    = (CW + 7) / 8;
    localparam int CPW   = 8 * CB;
    localparam int A_CTL = 0;
    localparam int A_PER = 1;
    localparam int A_CB  = A_PER + BB;
    localparam int A_CO  = A_CB + NCH * BB;
    localparam int A_CAP = A_CO + NCH * OB;
    localparam int A_RT  = A_CAP + CB;

    logic                          en_q;
    logic [8*BB-1:0]               per_q;
    logic [NCH-1:0][8*BB-1:0]      cb_q;
    logic [NCH-1:0][8*OB-1:0]      co_q;
    logic [CW-1:0]                 cap_q;
    logic [CPW-1:0]                cap_pad;
    logic [CPW-1:0]                shd_q;
    logic [7:0]                    rt_q;
    logic                          evt_any;
    logic                          shd_load;

    assign evt_any  = evt_sof || evt_eop;
    assign shd_load = bus_rd && (bus_addr == ADDR_W'(A_CAP));
    assign cap_pad  = CPW'(cap_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            per_q <= '1;
            cb_q  <= '0;
            co_q  <= '0;
            rt_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_CTL)) en_q <= bus_wdata[0];
            if (bus_addr == ADDR_W'(A_RT))  rt_q <= bus_wdata;
            for (int b = 0; b < BB; b++)
                if (bus_addr == ADDR_W'(A_PER + b)) per_q[8*b +: 8] <= bus_wdata;
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < BB; b++)
                    if (bus_addr == ADDR_W'(A_CB + c*BB + b)) cb_q[c][8*b +: 8] <= bus_wdata;
                for (int b = 0; b < OB; b++)
                    if (bus_addr == ADDR_W'(A_CO + c*OB + b)) co_q[c][8*b +: 8] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            shd_q <= '0;
        end else begin
            if (evt_any)  cap_q <= {ovf_cnt, base_cnt};
            if (shd_load) shd_q <= cap_pad;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTL)) bus_rdata = {7'b0, en_q};
        if (bus_addr == ADDR_W'(A_RT))  bus_rdata = rt_q;
        for (int b = 0; b < BB; b++)
            if (bus_addr == ADDR_W'(A_PER + b)) bus_rdata = per_q[8*b +: 8];
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < BB; b++)
                if (bus_addr == ADDR_W'(A_CB + c*BB + b)) bus_rdata = cb_q[c][8*b +: 8];
            for (int b = 0; b < OB; b++)
                if (bus_addr == ADDR_W'(A_CO + c*OB + b)) bus_rdata = co_q[c][8*b +: 8];
        end
        if (bus_addr == ADDR_W'(A_CAP)) bus_rdata = cap_pad[7:0];
        for (int b = 1; b < CB; b++)
            if (bus_addr == ADDR_W'(A_CAP + b)) bus_rdata = shd_q[8*b +: 8];
    end

    assign run_en = en_q;
    assign period = per_q[BASE_W-1:0];
    assign route  = rt_q;

    for (genvar c = 0; c < NCH; c++) begin : g_cmp_out
        assign cmp_base[c] = cb_q[c][BASE_W-1:0];
        assign cmp_ovf[c]  = co_q[c][OVF_W-1:0];
    end

    // R3: a strobe freezes the live counter pair into the capture register
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any |=> (cap_q == $past({ovf_cnt, base_cnt})));

    // R4: the shadow only changes on a byte-0 capture read
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shd_load |=> $stable(shd_q));
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top #(
    parameter int BASE_W = 16,
    parameter int OVF_W  = 24,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              evt_sof,
    input  logic              evt_eop,
    output logic              start_rx,
    output logic              start_tx,
    output logic              evt_irq
);
    import ftmr_pkg::*;

    logic                          run_en;
    logic [BASE_W-1:0]             period;
    logic [NCH-1:0][BASE_W-1:0]    cmp_base;
    logic [NCH-1:0][OVF_W-1:0]     cmp_ovf;
    logic [7:0]                    route;
    logic [BASE_W-1:0]             base_q, base_nx;
    logic [OVF_W-1:0]              ovf_q, ovf_nx;
    logic                          tick, wrap;
    logic [NCH-1:0]                base_hit, ovf_hit;
    logic [NSRC-1:0]               src_hit;

    ftmr_regs #(.BASE_W(BASE_W), .OVF_W(OVF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_sof(evt_sof), .evt_eop(evt_eop), .base_cnt(base_q), .ovf_cnt(ovf_q),
        .run_en(run_en), .period(period), .cmp_base(cmp_base), .cmp_ovf(cmp_ovf),
        .route(route)
    );

    ftmr_count #(.BASE_W(BASE_W), .OVF_W(OVF_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .period(period),
        .base_q(base_q), .ovf_q(ovf_q), .base_nx(base_nx), .ovf_nx(ovf_nx),
        .tick(tick), .wrap(wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_match
        ftmr_match #(.W(BASE_W)) u_base (
            .clk(clk), .rst_n(rst_n), .step(tick), .cnt_nx(base_nx),
            .cnt_q(base_q), .cmp(cmp_base[c]), .hit(base_hit[c])
        );
        ftmr_match #(.W(OVF_W)) u_ovf (
            .clk(clk), .rst_n(rst_n), .step(wrap), .cnt_nx(ovf_nx),
            .cnt_q(ovf_q), .cmp(cmp_ovf[c]), .hit(ovf_hit[c])
        );

        // R6: an overflow match lasts exactly one cycle
        assert_ovf_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_hit[c] |=> !ovf_hit[c]);

        // R5: a base match lasts one cycle whenever the period is above zero
        assert_base_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (base_hit[c] && (period != '0)) |=> !base_hit[c]);
    end

    assign src_hit = {ovf_hit, base_hit};

    always_comb begin
        start_rx = 1'b0;
        start_tx = 1'b0;
        evt_irq  = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_hit[s] && route[2*s +: 2] == RT_RX)  start_rx = 1'b1;
            if (src_hit[s] && route[2*s +: 2] == RT_TX)  start_tx = 1'b1;
            if (src_hit[s] && route[2*s +: 2] == RT_IRQ) evt_irq  = 1'b1;
        end
    end
endmodule

// File: tb/ftmr_top_bench.sv
`timescale 1ns/1ps
module ftmr_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_sof = 1'b0, evt_eop = 1'b0;
    logic       start_rx, start_tx, evt_irq;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int wr_edge, cap_edge;
    bit done = 0;

    int rx_n, tx_n, irq_n, rx_first, tx_first, irq_first;
    bit mon_on = 0;

    ftmr_top u_ftmr_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_sof(evt_sof), .evt_eop(evt_eop),
        .start_rx(start_rx), .start_tx(start_tx), .evt_irq(evt_irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (mon_on) begin
            if (start_rx) begin if (rx_n == 0) rx_first = cyc; rx_n++; end
            if (start_tx) begin if (tx_n == 0) tx_first = cyc; tx_n++; end
            if (evt_irq)  begin if (irq_n == 0) irq_first = cyc; irq_n++; end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic wr(input int a, input int d);
        bus_addr  = 5'(a);
        bus_wdata = 8'(d);
        bus_wr    = 1'b1;
        wr_edge   = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        bus_addr = 5'(a);
        bus_rd   = 1'b1;
        #1;
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic strobe(input bit eop);
        if (eop) evt_eop = 1'b1; else evt_sof = 1'b1;
        cap_edge = cyc + 1;
        @(negedge clk);
        evt_sof = 1'b0;
        evt_eop = 1'b0;
    endtask

    task automatic read_cap(output longint v);
        logic [7:0] b;
        v = 0;
        rd(13, b);
        v = longint'(b);
        for (int i = 1; i < 5; i++) begin
            rd(13 + i, b);
            v = v | (longint'(b) << (8 * i));
        end
    endtask

    function automatic longint tval(input longint n, input longint p);
        return ((n / (p + 1)) << 16) | (n % (p + 1));
    endfunction

    task automatic mon_clear();
        rx_n = 0; tx_n = 0; irq_n = 0;
        rx_first = -1; tx_first = -1; irq_first = -1;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        longint c;
        do_reset();
        rd(0, v);  check("R9 ctrl reset", v, 0);
        rd(1, v);  check("R9 period low reset", v, 8'hFF);
        rd(2, v);  check("R9 period high reset", v, 8'hFF);
        rd(18, v); check("R9 route reset", v, 0);
        rd(7, v);  check("R9 ovf compare reset", v, 0);
        check("R9 outputs low", {start_rx, start_tx, evt_irq}, 0);
        read_cap(c); check("R9 capture reset", c, 0);
        wr(5, 8'h5A); rd(5, v); check("R9 compare readback", v, 8'h5A);
    endtask

    task automatic t_count_capture();
        int en;
        longint c;
        do_reset();
        wr(1, 9); wr(2, 0);
        wr(0, 1); en = wr_edge;
        idle(37);
        strobe(0);
        read_cap(c); check("R1 R2 R8 sof capture", c, tval(cap_edge - en - 2, 9));
        idle(12);
        strobe(1);
        read_cap(c); check("R3 eop capture", c, tval(cap_edge - en - 2, 9));
    endtask

    task automatic t_coherent_read();
        int en, ca;
        logic [7:0] b;
        longint c, ea, eb;
        do_reset();
        wr(1, 9); wr(2, 0);
        wr(0, 1); en = wr_edge;
        idle(20);
        strobe(0); ca = cap_edge; ea = tval(ca - en - 2, 9);
        rd(13, b); check("R4 byte0", b, ea & 8'hFF);
        idle(15);
        strobe(1); eb = tval(cap_edge - en - 2, 9);
        c = longint'(b);
        for (int i = 1; i < 5; i++) begin
            rd(13 + i, b);
            c = c | (longint'(b) << (8 * i));
        end
        check("R4 shadow coherent", c, ea);
        read_cap(c); check("R4 fresh read", c, eb);
    endtask

    task automatic t_freeze();
        int en, dis, en2;
        longint c, held;
        do_reset();
        wr(1, 9); wr(2, 0);
        wr(0, 1); en = wr_edge;
        idle(25);
        wr(0, 0); dis = wr_edge;
        held = tval(dis - en, 9);
        idle(10);
        strobe(0); read_cap(c); check("R8 frozen value", c, held);
        idle(20);
        strobe(1); read_cap(c); check("R8 still frozen", c, held);
        wr(0, 1); en2 = wr_edge;
        idle(13);
        strobe(0); read_cap(c);
        check("R8 resume", c, tval((dis - en) + (cap_edge - en2 - 2), 9));
    endtask

    task automatic t_base_match();
        int en;
        do_reset();
        wr(1, 9); wr(2, 0);
        wr(3, 5); wr(5, 7);
        wr(18, 8'h07);
        mon_clear(); mon_on = 1;
        wr(0, 1); en = wr_edge;
        while (cyc < en + 30) @(negedge clk);
        mon_on = 0;
        check("R5 base0 first pulse edge", irq_first, en + 6);
        check("R5 base0 pulse count", irq_n, 3);
        check("R7 base1 routed to rx first", rx_first, en + 8);
        check("R7 base1 rx count", rx_n, 3);
        check("R7 no tx route", tx_n, 0);
    endtask

    task automatic t_ovf_match();
        int en;
        do_reset();
        wr(1, 3); wr(2, 0);
        wr(7, 2); wr(10, 5);
        wr(18, 8'hE0);
        mon_clear(); mon_on = 1;
        wr(0, 1); en = wr_edge;
        while (cyc < en + 30) @(negedge clk);
        mon_on = 0;
        check("R6 ovf0 tx edge", tx_first, en + 9);
        check("R6 ovf0 tx count", tx_n, 1);
        check("R6 ovf1 irq edge", irq_first, en + 21);
        check("R6 ovf1 irq count", irq_n, 1);
        check("R7 unrouted base sources", rx_n, 0);
    endtask

    task automatic t_period_lower();
        int en, w;
        longint c;
        do_reset();
        wr(1, 200); wr(2, 0);
        wr(0, 1); en = wr_edge;
        idle(40);
        wr(1, 9); w = wr_edge;
        idle(24);
        strobe(0); read_cap(c);
        check("R1 lowered period wrap", c,
              ((1 + longint'(cap_edge - w - 2) / 10) << 16) | (longint'(cap_edge - w - 2) % 10));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_count_capture();
        t_coherent_read();
        t_freeze();
        t_base_match();
        t_ovf_match();
        t_period_lower();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule